// File: doc/BRIEF.md
# Dual-Mode Multiply-Accumulate Unit

This block is a multiply-accumulate datapath. It accepts one operation per clock and returns each result exactly one cycle later. A single array of four signed quadrant multipliers carries every operation. In wide mode the four quadrants combine into a full 32x32 product, and that product is added to a 64-bit accumulator input. The operands are treated as signed or unsigned, chosen per operation.

In the two dot-product modes, each 32-bit operand is split into two signed 16-bit halves. Only the two diagonal quadrants are used. They form the low-by-low and high-by-high products, and both products are added to the accumulator in the same cycle. An exchange control swaps the halves of the second operand first, so the cross products are formed instead.

The narrow dot mode accumulates in 32 bits. It wraps on overflow and sets a sticky overflow flag. The wide dot mode sign-extends the product sum and adds it to all 64 accumulator bits. A surrounding pipeline supplies the operands and the accumulator value, and it takes the registered result.

Top module: `dual_mac`

## Requirements
- R1: With `op_code` = 2'b00 and `op_signed` = 0, `result` = (opa × opb, both unsigned) + `acc_in`, modulo 2^64.
- R2: With `op_code` = 2'b00 and `op_signed` = 1, `result` = (opa × opb, both two's complement) + `acc_in`, modulo 2^64. `op_exchange` has no effect in this mode.
- R3: With `op_code` = 2'b01 and `op_exchange` = 0, the 32-bit sum is S = acc_in[31:0] + opa[15:0]·opb[15:0] + opa[31:16]·opb[31:16]. Every halfword and acc_in[31:0] are signed. `result` is S wrapped to 32 bits and sign-extended to 64 bits. `op_signed` has no effect.
- R4: With `op_exchange` = 1 in either dot mode, the halves of opb are swapped before multiplying. The products become opa[15:0]·opb[31:16] and opa[31:16]·opb[15:0].
- R5: With `op_code` = 2'b10, `result` = `acc_in` + (sign-extended sum of the two signed halfword products), modulo 2^64.
- R6: In mode 2'b01, when the exact value of S lies outside [-2^31, 2^31-1], `ovf_flag` rises. It rises in the same cycle that the wrapped result appears, and it stays high until reset. No other mode ever sets it.
- R7: `out_valid` and `result` follow an accepted `in_valid` by exactly one clock. Back-to-back operations produce a new result every cycle.
- R8: While `in_valid` is low, `out_valid` is low on the next cycle and `result` holds its last value, whatever the other inputs do.
- R9: `op_code` = 2'b11 is reserved. When accepted, it gives `result` = 0 and leaves `ovf_flag` unchanged.
- R10: While `rst_n` is low, `out_valid`, `result` and `ovf_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_code | input | 2 | 00 wide, 01 dot with 32-bit accumulate, 10 dot with 64-bit accumulate, 11 reserved |
| op_signed | input | 1 | Signed operands in wide mode |
| op_exchange | input | 1 | Swap the opb halves in the dot modes |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| acc_in | input | 64 | Accumulator addend |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Registered result |
| ovf_flag | output | 1 | Sticky overflow of the 32-bit dot accumulate |

## Verification
Every result, its strobe and any change of the overflow flag are due on the first rising edge after the operation is presented. Inputs are driven on the falling edge. Each operation's expected value is held as pending and compared on the next falling edge, when the new operation is driven. A stream of operations therefore checks the one-cycle latency and the one-per-cycle throughput together. The hold and reset cases are checked over idle cycles on the same falling-edge grid.

// File: rtl/dual_mac_pkg.sv
package dual_mac_pkg;

    typedef enum logic [1:0] {
        MAC_WIDE  = 2'b00,
        MAC_DOT32 = 2'b01,
        MAC_DOT64 = 2'b10,
        MAC_RSVD  = 2'b11
    } mac_op_e;

    // quadrant count of the shared multiplier array (2 x 2 halves)
    localparam int QUAD_N = 4;

endpackage

// File: rtl/dual_mac_quad.sv
module dual_mac_quad #(
    parameter int HALF_W = 16
) (
    input  logic signed [HALF_W:0]     x_i,
    input  logic signed [HALF_W:0]     y_i,
    output logic signed [2*HALF_W+1:0] p_o
);
    // one extended-halfword signed multiplier
    always_comb begin
        p_o = x_i * y_i;
    end
endmodule

// File: rtl/dual_mac_array.sv
module dual_mac_array
    import dual_mac_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0]        a_i,
    input  logic [2*HALF_W-1:0]        b_i,
    input  logic                       dual_i,
    input  logic                       sgn_i,
    input  logic                       xchg_i,
    output logic [4*HALF_W-1:0]        wide_o,
    output logic signed [2*HALF_W+1:0] dot_lo_o,
    output logic signed [2*HALF_W+1:0] dot_hi_o
);
    localparam int OP_W  = 2 * HALF_W;
    localparam int ACC_W = 4 * HALF_W;
    localparam int PP_W  = 2 * HALF_W + 2;

    logic [OP_W-1:0]          b_eff;
    logic signed [HALF_W:0]   xs [2];
    logic signed [HALF_W:0]   ys [2];
    logic signed [PP_W-1:0]   pp [QUAD_N];

    always_comb begin
        b_eff = (dual_i && xchg_i) ? {b_i[HALF_W-1:0], b_i[OP_W-1:HALF_W]} : b_i;
        // low halves are signed only in the dot modes
        xs[0] = {dual_i ? a_i[HALF_W-1] : 1'b0, a_i[HALF_W-1:0]};
        ys[0] = {dual_i ? b_eff[HALF_W-1] : 1'b0, b_eff[HALF_W-1:0]};
        // high halves are signed in the dot modes or for signed wide ops
        xs[1] = {(dual_i || sgn_i) ? a_i[OP_W-1] : 1'b0, a_i[OP_W-1:HALF_W]};
        ys[1] = {(dual_i || sgn_i) ? b_eff[OP_W-1] : 1'b0, b_eff[OP_W-1:HALF_W]};
    end

    for (genvar qa = 0; qa < 2; qa++) begin : g_row
        for (genvar qb = 0; qb < 2; qb++) begin : g_col
            dual_mac_quad #(.HALF_W(HALF_W)) u_quad (
                .x_i (xs[qa]),
                .y_i (ys[qb]),
                .p_o (pp[qa*2+qb])
            );
        end
    end

    always_comb begin
        wide_o = '0;
        for (int q = 0; q < QUAD_N; q++) begin
            wide_o = wide_o + (ACC_W'(pp[q]) << (HALF_W * ((q >> 1) + (q & 1))));
        end
        dot_lo_o = pp[0];
        dot_hi_o = pp[QUAD_N-1];
    end
endmodule

// File: rtl/dual_mac.sv
module dual_mac
    import dual_mac_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [1:0]            op_code,
    input  logic                  op_signed,
    input  logic                  op_exchange,
    input  logic [2*HALF_W-1:0]   opa,
    input  logic [2*HALF_W-1:0]   opb,
    input  logic [4*HALF_W-1:0]   acc_in,
    output logic                  out_valid,
    output logic [4*HALF_W-1:0]   result,
    output logic                  ovf_flag
);
    localparam int OP_W  = 2 * HALF_W;
    localparam int ACC_W = 4 * HALF_W;
    localparam int PP_W  = 2 * HALF_W + 2;
    localparam int EX_W  = OP_W + 2;

    typedef struct packed {
        logic             vld;
        logic [ACC_W-1:0] res;
        logic             ovf;
    } mac_state_t;

    mac_state_t st_d, st_q;
    mac_op_e    op_e;
    logic       dual_sel;

    logic [ACC_W-1:0]        wide_prod;
    logic signed [PP_W-1:0]  dot_lo, dot_hi;
    logic signed [EX_W-1:0]  exact32;
    logic signed [PP_W:0]    dot_sum;

    always_comb begin
        op_e     = mac_op_e'(op_code);
        dual_sel = (op_e == MAC_DOT32) || (op_e == MAC_DOT64);
    end

    dual_mac_array #(.HALF_W(HALF_W)) u_array (
        .a_i      (opa),
        .b_i      (opb),
        .dual_i   (dual_sel),
        .sgn_i    (op_signed),
        .xchg_i   (op_exchange),
        .wide_o   (wide_prod),
        .dot_lo_o (dot_lo),
        .dot_hi_o (dot_hi)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        exact32  = EX_W'($signed(acc_in[OP_W-1:0])) + EX_W'(dot_lo) + EX_W'(dot_hi);
        dot_sum  = (PP_W+1)'(dot_lo) + (PP_W+1)'(dot_hi);
        if (in_valid) begin
            unique case (op_e)
                MAC_WIDE:  st_d.res = wide_prod + acc_in;
                MAC_DOT32: begin
                    st_d.res = ACC_W'($signed(exact32[OP_W-1:0]));
                    if ((exact32[EX_W-1:OP_W-1] != '0) && (exact32[EX_W-1:OP_W-1] != '1))
                        st_d.ovf = 1'b1;
                end
                MAC_DOT64: st_d.res = acc_in + ACC_W'(dot_sum);
                default:   st_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign ovf_flag  = st_q.ovf;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && !out_valid); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag); // R6
    AST_OVF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(in_valid && op_code == 2'b01)); // R6
    AST_DOT32_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && op_code == 2'b01) |->
            (result[ACC_W-1:OP_W-1] == '0 || result[ACC_W-1:OP_W-1] == '1)); // R3
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && op_code == 2'b11) |-> result == '0 && ovf_flag == $past(ovf_flag)); // R9
endmodule

// File: tb/dual_mac_test.sv
`timescale 1ns/1ps
module dual_mac_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic        op_signed = 1'b0;
    logic        op_exchange = 1'b0;
    logic [31:0] opa = '0, opb = '0;
    logic [63:0] acc_in = '0;
    logic        out_valid, ovf_flag;
    logic [63:0] result;

    int checks = 0, errors = 0;
    bit done = 0;

    logic        pend = 0;
    logic [63:0] pend_res;
    logic        pend_ovf;
    string       pend_tag;
    logic        model_ovf = 0;
    logic [63:0] last_res = '0;

    always #2 clk = ~clk;

    dual_mac uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .op_signed(op_signed), .op_exchange(op_exchange), .opa(opa), .opb(opb),
        .acc_in(acc_in), .out_valid(out_valid), .result(result), .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [1:0] op, input logic sgn, input logic xchg,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [63:0] acc, output logic ov);
        logic [31:0] bb;
        longint s, sa, sb;
        ov = 1'b0;
        bb = xchg ? {b[15:0], b[31:16]} : b;
        s = longint'($signed(a[15:0])) * longint'($signed(bb[15:0]))
          + longint'($signed(a[31:16])) * longint'($signed(bb[31:16]));
        case (op)
            2'b00: begin
                if (sgn) begin
                    sa = longint'($signed(a));
                    sb = longint'($signed(b));
                    return 64'(sa * sb) + acc;
                end
                return ({32'b0, a} * {32'b0, b}) + acc;
            end
            2'b01: begin
                s = s + longint'($signed(acc[31:0]));
                ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
                return {{32{s[31]}}, s[31:0]};
            end
            2'b10: return acc + 64'(s);
            default: return 64'h0;
        endcase
    endfunction

    // called at a falling edge: checks the previous op, drives the next one
    task automatic step(input bit v, input logic [1:0] op, input logic sgn, input logic xchg,
                        input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc,
                        input string tag);
        logic ov;
        logic [63:0] e;
        if (pend) begin
            chk(out_valid === 1'b1 && result === pend_res && ovf_flag === pend_ovf,
                {pend_tag, "/R7"}, result, pend_res);
            last_res = pend_res;
        end
        in_valid = v; op_code = op; op_signed = sgn; op_exchange = xchg;
        opa = a; opb = b; acc_in = acc;
        pend = v;
        if (v) begin
            e = model(op, sgn, xchg, a, b, acc, ov);
            if (ov) model_ovf = 1'b1;
            pend_res = e; pend_ovf = model_ovf; pend_tag = tag;
        end
        @(negedge clk);
    endtask

    logic [31:0] vals [8] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_8000,
                              32'h8000_7FFF, 32'h8000_8000, 32'h1234_ABCD, 32'h7FFF_7FFF};
    logic [63:0] accs [4] = '{64'h0, 64'hFFFF_FFFF_8000_0000, 64'h0000_0001_7FFF_FFF0,
                              64'h8000_0000_0000_0005};

    task automatic sweep(input logic [1:0] op, input logic sgn, input logic xchg, input string tag);
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                step(1'b1, op, sgn, xchg, vals[i], vals[j], accs[(i + j) % 4], tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            chk(1'b0, "watchdog", 64'h0, 64'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        chk(out_valid === 1'b0 && result === 64'h0 && ovf_flag === 1'b0, "R10 reset", result, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        sweep(2'b00, 1'b0, 1'b0, "R1 wide unsigned");
        sweep(2'b00, 1'b0, 1'b1, "R1 wide unsigned xchg");
        sweep(2'b00, 1'b1, 1'b0, "R2 wide signed");
        sweep(2'b00, 1'b1, 1'b1, "R2 wide signed xchg ignored");
        sweep(2'b10, 1'b0, 1'b0, "R5 dot64");
        sweep(2'b10, 1'b1, 1'b1, "R4 dot64 exchange");
        sweep(2'b11, 1'b0, 1'b0, "R9 reserved");
        step(1'b0, 2'b00, 1'b0, 1'b0, '0, '0, '0, "idle");
        chk(ovf_flag === 1'b0, "R6 no ovf from other modes", 64'(ovf_flag), 64'h0);

        // single overflowing op: flag must appear with its own result
        step(1'b1, 2'b01, 1'b0, 1'b0, 32'h8000_8000, 32'h8000_8000, 64'h0, "R6 ovf rise");
        step(1'b0, 2'b00, 1'b0, 1'b0, '0, '0, '0, "idle");
        chk(ovf_flag === 1'b1 && result === 64'hFFFF_FFFF_8000_0000, "R6 ovf wrap",
            result, 64'hFFFF_FFFF_8000_0000);

        sweep(2'b01, 1'b0, 1'b0, "R3 dot32");
        sweep(2'b01, 1'b1, 1'b1, "R4 dot32 exchange");
        step(1'b1, 2'b11, 1'b0, 1'b0, 32'h5, 32'h7, 64'h9, "R9 reserved keeps ovf");
        step(1'b0, 2'b00, 1'b0, 1'b0, '0, '0, '0, "idle");

        // R8: idle cycles with changing inputs must not disturb the result
        for (int k = 0; k < 4; k++) begin
            in_valid = 1'b0; op_code = 2'(k); opa = 32'hDEAD_0000 + 32'(k);
            opb = 32'h0BAD_F00D; acc_in = 64'hFFFF_0000_1234_5678;
            @(negedge clk);
            chk(out_valid === 1'b0 && result === last_res && ovf_flag === 1'b1,
                "R8 hold while idle", result, last_res);
        end

        // R6/R10: reset clears the sticky flag
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0 && result === 64'h0 && ovf_flag === 1'b0, "R10 reset clears",
            {63'b0, ovf_flag}, 64'h0);
        rst_n = 1'b1;
        model_ovf = 1'b0;
        @(negedge clk);
        step(1'b1, 2'b01, 1'b0, 1'b0, 32'h0001_0002, 32'h0003_0004, 64'h10, "R3 after reset");
        step(1'b0, 2'b00, 1'b0, 1'b0, '0, '0, '0, "idle");
        chk(ovf_flag === 1'b0 && result === 64'h1B, "R6 flag stays clear", result, 64'h1B);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule